// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block collects thirty-two level-sensitive, active-high interrupt request lines and assigns each a programmable five-bit priority level. Among the requests that are currently high and whose level lies strictly below a software-set threshold, it picks the one with the numerically smallest level. Ties go to the lower source number. When a global enable bit is set and a winner exists, the block raises a single interrupt line towards the processor.

Alongside the interrupt line, the block forms a vector. The vector is the base address of a relocatable vector table plus four times the winning source number. Interrupt software reads this vector to jump straight to the right table entry.

All configuration is held in a word-addressed register bank behind a plain write-enable and combinational read port. The bank holds the per-source levels, the threshold, the table base, the read-only vector and the enable bit. The arbitration is purely combinational, so the interrupt line and the vector follow the request inputs and the configuration within the same cycle.

Top module: `vpic_top`

## Requirements
- R1: After synchronous reset every source level reads 31, the threshold reads 0, the table base reads 0 and the enable reads 0, and `irq_o` stays low whatever the request inputs are.
- R2: Register word addresses: 0 to 31 are the source levels (bits 4:0), 32 is the threshold (bits 4:0), 33 is the table base (bits 31:0), 34 is the read-only vector, and 35 is the enable (bit 0). Unused read bits and unmapped addresses read 0. Writes to address 34 or to unmapped addresses change no register.
- R3: A source is eligible only when its request input is high, its level is strictly below the threshold, and its level is not 31. A source with level 31 is never eligible.
- R4: The winner is the eligible source with the lowest level value. Among equal levels, the lowest source number wins.
- R5: The vector equals table base + 4 × winner number, modulo 2^32. With no eligible source it equals the table base. It tracks the request inputs in the same cycle.
- R6: `irq_o` is high exactly when the enable is 1 and at least one source is eligible. It falls in the same cycle in which the last eligible request drops.
- R7: The enable bit gates only `irq_o`; the vector does not depend on it.
- R8: A register write presented in one cycle becomes visible on reads and in arbitration after the next rising clock edge, not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req_i | input | 32 | Level-sensitive interrupt requests, bit n is source n |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 6 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Combinational register read data |
| irq_o | output | 1 | Interrupt line to the processor |
| vector_o | output | 32 | Vector address of the current winner |

## Verification
The bench first runs directed patterns. Two sources at the same level separate a correct lowest-number tie break from an inverted one. A lower level on a higher source number separates priority by level from priority by position. A level equal to the threshold, and a level of 31 under the maximum threshold, expose an off-by-one in the comparison. Clearing the enable with requests pending separates gating of the interrupt line from gating of the vector. After that, random levels, thresholds, bases and request masks are compared against a bench model of the arbitration. These random patterns catch faults that appear only for particular source positions in the selection tree.

// File: rtl/vpic_pkg.sv
package vpic_pkg;

    parameter int unsigned NUM_SRC = 32;
    parameter int unsigned LVL_W   = 5;
    parameter int unsigned DATA_W  = 32;
    parameter int unsigned ADDR_W  = 6;

    localparam int unsigned SRC_W = $clog2(NUM_SRC);
    localparam int unsigned NPOW  = 1 << SRC_W;
    localparam logic [LVL_W-1:0] LVL_OFF = '1;

    localparam int unsigned ADR_THR  = NUM_SRC;
    localparam int unsigned ADR_BASE = NUM_SRC + 1;
    localparam int unsigned ADR_VEC  = NUM_SRC + 2;
    localparam int unsigned ADR_EN   = NUM_SRC + 3;

    typedef enum logic [2:0] {
        SEL_LVL,
        SEL_THR,
        SEL_BASE,
        SEL_VEC,
        SEL_EN,
        SEL_NONE
    } reg_sel_e;

    typedef struct packed {
        logic             valid;
        logic [LVL_W-1:0] lvl;
        logic [SRC_W-1:0] id;
    } cand_t;

    function automatic reg_sel_e decode_addr(logic [ADDR_W-1:0] a);
        if (int'(a) < NUM_SRC)       return SEL_LVL;
        else if (int'(a) == ADR_THR) return SEL_THR;
        else if (int'(a) == ADR_BASE) return SEL_BASE;
        else if (int'(a) == ADR_VEC) return SEL_VEC;
        else if (int'(a) == ADR_EN)  return SEL_EN;
        return SEL_NONE;
    endfunction

    // Left operand always covers lower source numbers, so it keeps ties.
    function automatic cand_t pick(cand_t lo, cand_t hi);
        if (!hi.valid) return lo;
        if (!lo.valid) return hi;
        if (hi.lvl < lo.lvl) return hi;
        return lo;
    endfunction

endpackage

// File: rtl/vpic_regs.sv
module vpic_regs
    import vpic_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          we_i,
    input  logic [ADDR_W-1:0]             addr_i,
    input  logic [DATA_W-1:0]             wdata_i,
    input  logic [DATA_W-1:0]             vec_i,
    output logic [DATA_W-1:0]             rdata_o,
    output logic [NUM_SRC-1:0][LVL_W-1:0] lvl_o,
    output logic [LVL_W-1:0]              thr_o,
    output logic [DATA_W-1:0]             base_o,
    output logic                          en_o
);

    reg_sel_e sel;
    assign sel = decode_addr(addr_i);

    genvar gi;
    generate
        for (gi = 0; gi < NUM_SRC; gi++) begin : g_lvl
            always_ff @(posedge clk) begin
                if (rst)
                    lvl_o[gi] <= LVL_OFF;
                else if (we_i && addr_i == ADDR_W'(gi))
                    lvl_o[gi] <= wdata_i[LVL_W-1:0];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            thr_o  <= '0;
            base_o <= '0;
            en_o   <= 1'b0;
        end else if (we_i) begin
            case (sel)
                SEL_THR:  thr_o  <= wdata_i[LVL_W-1:0];
                SEL_BASE: base_o <= wdata_i;
                SEL_EN:   en_o   <= wdata_i[0];
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata_o = '0;
        case (sel)
            SEL_LVL:  rdata_o = DATA_W'(lvl_o[addr_i[SRC_W-1:0]]);
            SEL_THR:  rdata_o = DATA_W'(thr_o);
            SEL_BASE: rdata_o = base_o;
            SEL_VEC:  rdata_o = vec_i;
            SEL_EN:   rdata_o = DATA_W'(en_o);
            default:  rdata_o = '0;
        endcase
    end

    // Vector address and unmapped words hold no storage.
    assert_ro_vector_R2: assert property (@(posedge clk) disable iff (rst)
        (we_i && (sel == SEL_VEC || sel == SEL_NONE)) |=>
            ($stable(thr_o) && $stable(base_o) && $stable(en_o) && $stable(lvl_o)));

    // R1: configuration comes out of reset in the quiet state.
    always_ff @(posedge clk) begin
        if (!rst && $past(rst)) begin
            assert_reset_state_R1: assert (thr_o == '0 && base_o == '0 && !en_o);
        end
    end

endmodule

// File: rtl/vpic_arb.sv
module vpic_arb
    import vpic_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_SRC-1:0]            req_i,
    input  logic [NUM_SRC-1:0][LVL_W-1:0] lvl_i,
    input  logic [LVL_W-1:0]              thr_i,
    output cand_t                         win_o
);

    cand_t node [1:2*NPOW-1];

    genvar gi;
    generate
        for (gi = 0; gi < NPOW; gi++) begin : g_leaf
            if (gi < NUM_SRC) begin : g_real
                assign node[NPOW+gi] = '{
                    valid: req_i[gi] && (lvl_i[gi] < thr_i) && (lvl_i[gi] != LVL_OFF),
                    lvl:   lvl_i[gi],
                    id:    SRC_W'(gi)
                };
            end else begin : g_pad
                assign node[NPOW+gi] = '{valid: 1'b0, lvl: LVL_OFF, id: SRC_W'(gi)};
            end
        end
        for (gi = 1; gi < NPOW; gi++) begin : g_node
            assign node[gi] = pick(node[2*gi], node[2*gi+1]);
        end
    endgenerate

    assign win_o = node[1];

    // Independent linear scan used only by the checks below.
    always_ff @(posedge clk) begin
        if (!rst) begin
            if (win_o.valid) begin
                assert_winner_eligible_R3: assert (req_i[win_o.id] &&
                    lvl_i[win_o.id] < thr_i && lvl_i[win_o.id] != LVL_OFF);
            end
            for (int i = 0; i < NUM_SRC; i++) begin
                if (req_i[i] && lvl_i[i] < thr_i && lvl_i[i] != LVL_OFF) begin
                    assert_winner_best_R4: assert (win_o.valid &&
                        (lvl_i[i] > win_o.lvl ||
                         (lvl_i[i] == win_o.lvl && i >= int'(win_o.id))));
                end
            end
        end
    end

endmodule

// File: rtl/vpic_vec.sv
module vpic_vec
    import vpic_pkg::*;
(
    input  logic [DATA_W-1:0] base_i,
    input  cand_t             win_i,
    output logic [DATA_W-1:0] vec_o
);

    localparam int unsigned STRIDE_SH = 2;

    logic [DATA_W-1:0] offset;

    always_comb begin
        offset = '0;
        if (win_i.valid)
            offset = DATA_W'(win_i.id) << STRIDE_SH;
        vec_o = base_i + offset;
    end

endmodule

// File: rtl/vpic_top.sv
module vpic_top
    import vpic_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_SRC-1:0]  irq_req_i,
    input  logic                reg_we_i,
    input  logic [ADDR_W-1:0]   reg_addr_i,
    input  logic [DATA_W-1:0]   reg_wdata_i,
    output logic [DATA_W-1:0]   reg_rdata_o,
    output logic                irq_o,
    output logic [DATA_W-1:0]   vector_o
);

    logic [NUM_SRC-1:0][LVL_W-1:0] lvl;
    logic [LVL_W-1:0]              thr;
    logic [DATA_W-1:0]             base;
    logic                          en;
    cand_t                         win;

    vpic_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .we_i    (reg_we_i),
        .addr_i  (reg_addr_i),
        .wdata_i (reg_wdata_i),
        .vec_i   (vector_o),
        .rdata_o (reg_rdata_o),
        .lvl_o   (lvl),
        .thr_o   (thr),
        .base_o  (base),
        .en_o    (en)
    );

    vpic_arb u_arb (
        .clk   (clk),
        .rst   (rst),
        .req_i (irq_req_i),
        .lvl_i (lvl),
        .thr_i (thr),
        .win_o (win)
    );

    vpic_vec u_vec (
        .base_i (base),
        .win_i  (win),
        .vec_o  (vector_o)
    );

    assign irq_o = en && win.valid;

    assert_irq_gated_R6: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (en && (irq_req_i != '0)));

    assert_vec_aligned_R5: assert property (@(posedge clk) disable iff (rst)
        (((vector_o - base) & DATA_W'(3)) == '0) &&
        ((vector_o - base) < DATA_W'(4 * NUM_SRC)));

    assert_vec_idle_R5: assert property (@(posedge clk) disable iff (rst)
        !win.valid |-> (vector_o == base));

endmodule

// File: tb/vpic_top_tb_top.sv
`timescale 1ns/1ps
module vpic_top_tb_top;
    import vpic_pkg::*;

    logic                clk = 1'b0;
    logic                rst;
    logic [NUM_SRC-1:0]  irq_req;
    logic                reg_we;
    logic [ADDR_W-1:0]   reg_addr;
    logic [DATA_W-1:0]   reg_wdata;
    logic [DATA_W-1:0]   reg_rdata;
    logic                irq;
    logic [DATA_W-1:0]   vector;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [LVL_W-1:0]  m_lvl [NUM_SRC];
    logic [LVL_W-1:0]  m_thr;
    logic [DATA_W-1:0] m_base;
    logic              m_en;

    always #2.5 clk = ~clk;

    vpic_top dut_i (
        .clk         (clk),
        .rst         (rst),
        .irq_req_i   (irq_req),
        .reg_we_i    (reg_we),
        .reg_addr_i  (reg_addr),
        .reg_wdata_i (reg_wdata),
        .reg_rdata_o (reg_rdata),
        .irq_o       (irq),
        .vector_o    (vector)
    );

    task automatic check(input string req, input logic [DATA_W-1:0] act,
                         input logic [DATA_W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    function automatic int exp_winner(input logic [NUM_SRC-1:0] r);
        int best = -1;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (r[i] && m_lvl[i] < m_thr && m_lvl[i] != LVL_OFF) begin
                if (best < 0 || m_lvl[i] < m_lvl[best]) best = i;
            end
        end
        return best;
    endfunction

    function automatic logic [DATA_W-1:0] exp_vector(input logic [NUM_SRC-1:0] r);
        int w = exp_winner(r);
        return (w < 0) ? m_base : m_base + DATA_W'(4 * w);
    endfunction

    task automatic wr(input int a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = ADDR_W'(a); reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
        if (a < NUM_SRC)       m_lvl[a] = d[LVL_W-1:0];
        else if (a == ADR_THR) m_thr = d[LVL_W-1:0];
        else if (a == ADR_BASE) m_base = d;
        else if (a == ADR_EN)  m_en = d[0];
    endtask

    task automatic rd_check(input string req, input int a,
                            input logic [DATA_W-1:0] exp);
        reg_addr = ADDR_W'(a);
        #0.5;
        check(req, reg_rdata, exp);
    endtask

    task automatic drive_check(input string req, input logic [NUM_SRC-1:0] r);
        int w;
        irq_req = r;
        #0.5;
        w = exp_winner(r);
        check({req, " irq"}, DATA_W'(irq), DATA_W'(m_en && w >= 0));
        check({req, " vector"}, vector, exp_vector(r));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        rst = 1'b1; irq_req = '0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
        for (int i = 0; i < NUM_SRC; i++) m_lvl[i] = LVL_OFF;
        m_thr = '0; m_base = '0; m_en = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        for (int i = 0; i < NUM_SRC; i++) rd_check("R1 level reset", i, 32'd31);
        rd_check("R1 threshold reset", ADR_THR, 32'd0);
        rd_check("R1 base reset", ADR_BASE, 32'd0);
        rd_check("R1 enable reset", ADR_EN, 32'd0);
        drive_check("R1 all requests", '1);
        irq_req = '0;

        // R2 map, masking, read-only vector, unmapped
        wr(5, 32'hFFFF_FFEA);
        rd_check("R2 level bits 4:0", 5, 32'h0000_000A);
        wr(ADR_BASE, 32'h1234_5670);
        rd_check("R2 base", ADR_BASE, 32'h1234_5670);
        wr(ADR_VEC, 32'hDEAD_BEEF);
        rd_check("R2 vector write ignored", ADR_BASE, 32'h1234_5670);
        rd_check("R2 vector reads base idle", ADR_VEC, 32'h1234_5670);
        wr(40, 32'hFFFF_FFFF);
        rd_check("R2 unmapped reads zero", 40, 32'd0);
        rd_check("R2 unmapped write ignored thr", ADR_THR, 32'd0);
        rd_check("R2 unmapped write ignored en", ADR_EN, 32'd0);
        wr(ADR_EN, 32'hFFFF_FFFF);
        rd_check("R2 enable bit 0", ADR_EN, 32'd1);

        // R8 write timing on threshold
        @(negedge clk);
        reg_we = 1'b1; reg_addr = ADDR_W'(ADR_THR); reg_wdata = 32'd20;
        #0.5 check("R8 before edge", reg_rdata, 32'd0);
        @(negedge clk);
        reg_we = 1'b0; m_thr = 5'd20;
        #0.5 check("R8 after edge", reg_rdata, 32'd20);

        // R4 tie and level priority
        wr(3, 32'd4); wr(9, 32'd4); wr(5, 32'd31);
        drive_check("R4 tie lower number", (32'h1 << 3) | (32'h1 << 9));
        check("R4 tie vector value", vector, 32'h1234_5670 + 32'd12);
        wr(20, 32'd2);
        drive_check("R4 lower level wins", (32'h1 << 3) | (32'h1 << 9) | (32'h1 << 20));
        check("R4 winner 20", vector, 32'h1234_5670 + 32'd80);

        // R3 level equal to threshold excluded, level 31 excluded
        wr(ADR_THR, 32'd4);
        drive_check("R3 level equals threshold", (32'h1 << 3) | (32'h1 << 9));
        check("R3 no irq at equal", DATA_W'(irq), 32'd0);
        wr(ADR_THR, 32'd31); wr(30, 32'd31); wr(31, 32'd30);
        drive_check("R3 level 31 disabled", 32'h4000_0000);
        drive_check("R3 level 30 under 31", 32'h8000_0000);
        check("R3 source 31 vector", vector, 32'h1234_5670 + 32'd124);

        // R7 enable only gates irq
        wr(ADR_EN, 32'd0);
        drive_check("R7 enable off", 32'h8000_0000);
        check("R7 vector kept", vector, 32'h1234_5670 + 32'd124);
        wr(ADR_EN, 32'd1);

        // R6 same-cycle drop
        drive_check("R6 request high", 32'h0010_0000);
        check("R6 irq high", DATA_W'(irq), 32'd1);
        drive_check("R6 request dropped", 32'h0);
        check("R6 irq low", DATA_W'(irq), 32'd0);

        // R5 base wraparound
        wr(ADR_BASE, 32'hFFFF_FFFC);
        drive_check("R5 wrap", 32'h0010_0000);
        check("R5 wrap value", vector, 32'h0000_004C);

        // Random configurations (R3 R4 R5 R6)
        for (int t = 0; t < 40; t++) begin
            for (int i = 0; i < NUM_SRC; i++) wr(i, DATA_W'($urandom_range(0, 31)));
            wr(ADR_THR, DATA_W'($urandom_range(0, 31)));
            wr(ADR_BASE, DATA_W'($urandom) & 32'hFFFF_FFFC);
            wr(ADR_EN, DATA_W'($urandom_range(0, 3) != 0));
            for (int k = 0; k < 20; k++) begin
                @(negedge clk);
                drive_check("R4 random", NUM_SRC'($urandom) & NUM_SRC'($urandom));
                rd_check("R5 random vector read", ADR_VEC, exp_vector(irq_req));
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule